// File: doc/BRIEF.md
# CAN Interrupt Flag and Vector Unit

This unit gathers the interrupt events of a CAN controller and turns them into one interrupt request for the host. There are nineteen sources: sixteen message-buffer completion events, plus bus-off, error and wake-up. Every source has a sticky flag, and each flag is gated by its own enable bit. The pending source of highest priority chooses the low five bits of an 8-bit vector number. The top three bits of the vector come from a base value that the host programs.

The host uses a small register port with single-cycle read and write strobes. To clear a flag, the host reads the flag register while the bit is set and then writes that bit as zero. The clear is discarded if a new event for the same source arrives between the read and the write, or in the same cycle as the write. Writing a one to a flag bit never changes it.

Top module: `can_irq_vector`

## Requirements
- R1: A transmit-done or receive-done pulse on buffer i sets bit i of the buffer flag register (address 0). The bit stays set until it is cleared by the host.
- R2: `irq_req` is high exactly when at least one flag is set and its enable bit is also set. With every source disabled, `irq_req` stays low.
- R3: A flag bit is cleared by a zero write to its register when the most recent access to that register was a read that returned the bit as 1.
- R4: Writing a 1 to a flag bit does not change it. Writing a 0 to a flag bit that was not read as 1 beforehand does not change it either.
- R5: When a new event for a source arrives after the qualifying read and before the zero write, the write does not clear that flag.
- R6: When an event arrives in the same cycle as a clearing write, the flag stays set.
- R7: The status flag register (address 2) holds bus-off in bit 0, error in bit 1 and wake-up in bit 2. These bits are set and cleared by the same rules as the buffer flags, one bit at a time.
- R8: Each source has its own enable bit:
  - buffer i uses bit i of the buffer mask register (address 1);
  - bus-off uses bit 0 and error uses bit 1 of the control register (address 3);
  - wake-up uses bit 0 of the configuration register (address 4).
  All of these registers read back as written.
- R9: `irq_vector` is {base, index}. The base is configuration bits [7:5]. The index belongs to the highest-priority pending enabled source: bus-off = 0, error = 1, wake-up = 2, buffer i = 3 + i. The lowest index wins. When nothing is pending, the index is 0.
- R10: After reset, all flags, enable bits and the base are zero, and `irq_req` is low.
- R11: Any write to a flag register uses up the pending read qualification. A second zero write with no read in between does not clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_tx_done | input | 16 | One-cycle transmit completion pulse per buffer |
| buf_rx_done | input | 16 | One-cycle receive completion pulse per buffer |
| busoff_evt | input | 1 | Bus-off event pulse |
| error_evt | input | 1 | Error event pulse |
| wake_evt | input | 1 | Wake-up event pulse |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe; data is valid in the same cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector number: base and source index |

## Verification
The clearing handshake is exercised with several orderings:
- a read followed by a zero write;
- a zero write with no read;
- a write of ones followed by a zero write;
- an event between the read and the write;
- an event in the same cycle as the write.

Each ordering separates a different element of the qualification logic: the read arming, the use-up on any write, the cancel on a new event, and the precedence of a same-cycle event. The vector is then tested with several sources pending at once while enable bits are switched on and off. This shows that priority is resolved on enabled flags and not on raw flags, and that the base is placed in the upper bits.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int BUF_N   = 16;
    localparam int SYS_N   = 3;
    localparam int SRC_N   = SYS_N + BUF_N;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int BASE_W  = 3;
    localparam int VEC_W   = BASE_W + IDX_W;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int CTRL_N  = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_BFLAG = 3'd0;
    localparam logic [ADDR_W-1:0] A_BMASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_SFLAG = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd4;

    // Bit position of the vector base inside the configuration register
    localparam int CFG_BASE_LSB = 5;

    typedef struct packed {
        logic [BUF_N-1:0]  bmask;
        logic [CTRL_N-1:0] cmask;   // bit0 bus-off, bit1 error
        logic              wmask;
        logic [BASE_W-1:0] base;
    } cfg_regs_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_hit,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] armed;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] clr;

    always_comb begin
        st_d = st_q;
        // A clear needs a previous qualifying read and a zero in the write data
        clr = {W{wr_hit}} & st_q.armed & ~wdata;
        // A new event wins over a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | evt;
        if (wr_hit) begin
            st_d.armed = '0;
        end else begin
            st_d.armed = st_q.armed | ({W{rd_hit}} & st_q.flag);
        end
        st_d.armed = st_d.armed & ~evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 19,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |pend;
        idx = '0;
        // Walk downwards so that the lowest set index is the one that remains
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_irq_vector.sv
module can_irq_vector
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUF_N-1:0]  buf_tx_done,
    input  logic [BUF_N-1:0]  buf_rx_done,
    input  logic              busoff_evt,
    input  logic              error_evt,
    input  logic              wake_evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);
    cfg_regs_t cfg_d, cfg_q;

    logic [BUF_N-1:0] buf_evt;
    logic [SYS_N-1:0] sys_evt;
    logic [BUF_N-1:0] bflag;
    logic [SYS_N-1:0] sflag;
    logic [SYS_N-1:0] smask;
    logic [SRC_N-1:0] pend;
    logic             pend_any;
    logic [IDX_W-1:0] pend_idx;

    // Transmit and receive completion share one flag
    assign buf_evt = buf_tx_done | buf_rx_done;
    assign sys_evt = {wake_evt, error_evt, busoff_evt};

    irq_flag_bank #(.W(BUF_N)) u_bflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (buf_evt),
        .rd_hit (reg_rd && reg_addr == A_BFLAG),
        .wr_hit (reg_wr && reg_addr == A_BFLAG),
        .wdata  (reg_wdata[BUF_N-1:0]),
        .flag   (bflag)
    );

    irq_flag_bank #(.W(SYS_N)) u_sflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (sys_evt),
        .rd_hit (reg_rd && reg_addr == A_SFLAG),
        .wr_hit (reg_wr && reg_addr == A_SFLAG),
        .wdata  (reg_wdata[SYS_N-1:0]),
        .flag   (sflag)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_addr)
                A_BMASK: cfg_d.bmask = reg_wdata[BUF_N-1:0];
                A_CTRL:  cfg_d.cmask = reg_wdata[CTRL_N-1:0];
                A_CFG: begin
                    cfg_d.wmask = reg_wdata[0];
                    cfg_d.base  = reg_wdata[CFG_BASE_LSB +: BASE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_BFLAG: reg_rdata[BUF_N-1:0]  = bflag;
            A_BMASK: reg_rdata[BUF_N-1:0]  = cfg_q.bmask;
            A_SFLAG: reg_rdata[SYS_N-1:0]  = sflag;
            A_CTRL:  reg_rdata[CTRL_N-1:0] = cfg_q.cmask;
            A_CFG: begin
                reg_rdata[0]                      = cfg_q.wmask;
                reg_rdata[CFG_BASE_LSB +: BASE_W] = cfg_q.base;
            end
            default: ;
        endcase
    end

    // Priority order: bus-off, error, wake-up, then buffers 0..15
    assign smask = {cfg_q.wmask, cfg_q.cmask};
    assign pend  = {bflag & cfg_q.bmask, sflag & smask};

    irq_prio_enc #(.N(SRC_N), .IDX_W(IDX_W)) u_enc (
        .pend (pend),
        .any  (pend_any),
        .idx  (pend_idx)
    );

    assign irq_req    = pend_any;
    assign irq_vector = {cfg_q.base, pend_any ? pend_idx : {IDX_W{1'b0}}};
endmodule

// File: rtl/can_irq_vector_chk.sv
module can_irq_vector_chk
    import can_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BUF_N-1:0]  buf_evt,
    input logic [SYS_N-1:0]  sys_evt,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [BUF_N-1:0]  bflag,
    input logic [SYS_N-1:0]  sflag,
    input logic [BASE_W-1:0] base,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vector
);
    logic [SRC_N-1:0] all_flags;
    assign all_flags = {bflag, sflag};

    assert_buf_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_evt != '0) |=> ((bflag & $past(buf_evt)) == $past(buf_evt)));

    assert_sys_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_evt != '0) |=> ((sflag & $past(sys_evt)) == $past(sys_evt)));

    assert_bflag_falls_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(bflag) & ~bflag) != '0) |-> ($past(reg_wr) && $past(reg_addr) == A_BFLAG));

    assert_sflag_falls_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sflag) & ~sflag) != '0) |-> ($past(reg_wr) && $past(reg_addr) == A_SFLAG));

    assert_no_flag_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (all_flags == '0) |-> !irq_req);

    assert_vector_form_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[VEC_W-1:IDX_W] == base && irq_vector[IDX_W-1:0] < IDX_W'(SRC_N)));
endmodule

bind can_irq_vector can_irq_vector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_evt    (buf_tx_done | buf_rx_done),
    .sys_evt    ({wake_evt, error_evt, busoff_evt}),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .bflag      (bflag),
    .sflag      (sflag),
    .base       (cfg_q.base),
    .irq_req    (irq_req),
    .irq_vector (irq_vector)
);

// File: tb/can_irq_vector_test.sv
module can_irq_vector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] buf_tx_done = '0;
    logic [15:0] buf_rx_done = '0;
    logic        busoff_evt = 1'b0;
    logic        error_evt = 1'b0;
    logic        wake_evt = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [2:0] BFLAG = 3'd0, BMASK = 3'd1, SFLAG = 3'd2, CTRL = 3'd3, CFG = 3'd4;

    always #5 clk = ~clk;

    can_irq_vector uut (
        .clk(clk), .rst_n(rst_n),
        .buf_tx_done(buf_tx_done), .buf_rx_done(buf_rx_done),
        .busoff_evt(busoff_evt), .error_evt(error_evt), .wake_evt(wake_evt),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic do_rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] tx, input logic [15:0] rx, input logic [2:0] sys);
        buf_tx_done = tx; buf_rx_done = rx;
        {wake_evt, error_evt, busoff_evt} = sys;
        @(negedge clk);
        buf_tx_done = '0; buf_rx_done = '0;
        {wake_evt, error_evt, busoff_evt} = 3'b000;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R10 irq_req", {31'd0, irq_req}, 32'd0);
        chk("R10 vector", {24'd0, irq_vector}, 32'd0);
        for (int a = 0; a < 5; a++) begin
            do_rd(3'(a), d);
            chk("R10 register", {16'd0, d}, 32'd0);
        end
    endtask

    task automatic t_buf_basic;
        logic [15:0] d;
        pulse('0, 16'h0020, 3'b000);
        do_rd(BFLAG, d);
        chk("R1 rx sets flag", {16'd0, d}, 32'h0020);
        chk("R2 masked no irq", {31'd0, irq_req}, 32'd0);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R3 read then zero clears", {16'd0, d}, 32'h0000);
        pulse(16'h8000, '0, 3'b000);
        do_rd(BFLAG, d);
        chk("R1 tx sets flag", {16'd0, d}, 32'h8000);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R3 tx flag clears", {16'd0, d}, 32'h0000);
    endtask

    task automatic t_no_arm;
        logic [15:0] d;
        pulse('0, 16'h0004, 3'b000);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R4 zero write without read", {16'd0, d}, 32'h0004);
        do_wr(BFLAG, 16'hFFFF);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R11 arming used by ones write", {16'd0, d}, 32'h0004);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R3 clear after fresh read", {16'd0, d}, 32'h0000);
    endtask

    task automatic t_race;
        logic [15:0] d;
        pulse('0, 16'h0200, 3'b000);
        do_rd(BFLAG, d);
        chk("R1 buffer 9 set", {16'd0, d}, 32'h0200);
        pulse(16'h0200, '0, 3'b000);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R5 event between read and write", {16'd0, d}, 32'h0200);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R3 clear after race", {16'd0, d}, 32'h0000);
    endtask

    task automatic t_same_cycle;
        logic [15:0] d;
        pulse('0, 16'h0800, 3'b000);
        do_rd(BFLAG, d);
        reg_addr = BFLAG; reg_wdata = 16'h0000; reg_wr = 1'b1;
        buf_rx_done = 16'h0800;
        @(negedge clk);
        reg_wr = 1'b0; buf_rx_done = '0;
        do_rd(BFLAG, d);
        chk("R6 same-cycle event wins", {16'd0, d}, 32'h0800);
        do_wr(BFLAG, 16'h0000);
        do_rd(BFLAG, d);
        chk("R3 clear after same-cycle case", {16'd0, d}, 32'h0000);
    endtask

    task automatic t_status;
        logic [15:0] d;
        pulse('0, '0, 3'b001);
        pulse('0, '0, 3'b010);
        pulse('0, '0, 3'b100);
        do_rd(SFLAG, d);
        chk("R7 status flags set", {16'd0, d}, 32'h0007);
        do_wr(SFLAG, 16'h0006);
        do_rd(SFLAG, d);
        chk("R7 clear bus-off only", {16'd0, d}, 32'h0006);
        do_wr(SFLAG, 16'h0000);
        do_rd(SFLAG, d);
        chk("R7 clear rest", {16'd0, d}, 32'h0000);
    endtask

    task automatic t_prio;
        logic [15:0] d;
        do_wr(CFG, 16'h00A0);
        do_wr(BMASK, 16'hFFFF);
        pulse('0, 16'h0088, 3'b000);
        chk("R2 irq raised", {31'd0, irq_req}, 32'd1);
        chk("R9 buffer 3 wins", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd6});
        pulse('0, '0, 3'b100);
        chk("R8 wake masked", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd6});
        do_wr(CFG, 16'h00A1);
        chk("R9 wake wins", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd2});
        pulse('0, '0, 3'b010);
        chk("R8 error masked", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd2});
        do_wr(CTRL, 16'h0002);
        chk("R9 error wins", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd1});
        pulse('0, '0, 3'b001);
        do_wr(CTRL, 16'h0003);
        chk("R9 bus-off wins", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd0});
        do_wr(CTRL, 16'h0000);
        chk("R8 control cleared", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd2});
        do_wr(CFG, 16'h00A0);
        do_wr(BMASK, 16'h0080);
        chk("R9 buffer 7 alone", {24'd0, irq_vector}, {24'd0, 3'b101, 5'd10});
        do_wr(BMASK, 16'h0000);
        chk("R2 all disabled", {31'd0, irq_req}, 32'd0);
        do_rd(BMASK, d);
        chk("R8 buffer mask readback", {16'd0, d}, 32'h0000);
        do_rd(CFG, d);
        chk("R8 config readback", {16'd0, d}, 32'h00A0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buf_basic();
        t_no_arm();
        t_race();
        t_same_cycle();
        t_status();
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule